// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block gathers the interrupt sources of two serial channels into a single interrupt request line. Each channel has a receive source, a transmit source and a break source. Set and clear events for receive and transmit service arrive as one-cycle pulses. Each channel has its own enable fields. A shared status-placement bit picks how the source code sits inside the vector byte.

Three things are presented to the host. The first is the registered request line. The second is a shared pending register with one bit per channel and per service type. The third is a vector byte that names the source most recently raised or serviced. Channel A has index 0 and channel B has index 1 on every per-channel port.

When one source of a channel is cleared while the other is still pending, the block re-raises the remaining source at once. The vector and the pending register then point at it, and software can service it next without polling.

Top module: `ivec_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `pend` is 4'b0000 and `vec` is 8'h06 (the no-interrupt code in the low form).
- R2: A receive set event on a channel makes that channel's receive pending bit 1 on the next cycle. The receive pending bits are `pend[3]` for A and `pend[1]` for B. The vector takes that channel's receive code.
- R3: A transmit set event always records a transmit request inside the channel. The transmit pending bit is set only when that channel's `tx_ie` is 1; these bits are `pend[2]` for A and `pend[0]` for B. The vector shows the transmit code, unless a receive request is pending on the same channel, in which case it shows the receive code.
- R4: The 3-bit source codes are: A receive 110, A transmit 100, B receive 010, B transmit 000, none 011. With `stat_hi`=0 the code sits in `vec[3:1]`; with `stat_hi`=1 it sits in `vec[6:4]`. All other vector bits are 0.
- R5: A clear event removes the matching pending bit. If nothing else is pending on that channel, the vector becomes the no-interrupt code in the form chosen by `stat_hi`.
- R6: Clearing the receive source while a transmit request is still pending re-raises the transmit source in the same update. The vector takes the transmit code, and the transmit pending bit is set if `tx_ie` is 1. Clearing the transmit source while receive is pending leaves the receive code in the vector.
- R7: `irq` is the OR over both channels of three terms: (`tx_ie` and a transmit request), (`rx_mode` equal to 01 or 10 and a receive request), and (`brk_ie` and `brk_stat`). An `rx_mode` of 00 or 11 never lets receive requests drive `irq`.
- R8: `irq` is registered. It reflects events and enable or status inputs one clock edge after they are presented.
- R9: If both channels have events in the same cycle, channel A's events decide the vector. If a set and a clear of the same source arrive together, the set wins. With no event in a cycle, the vector holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_set | input | 2 | Receive service request pulse per channel |
| rx_clr | input | 2 | Receive service done pulse per channel |
| tx_set | input | 2 | Transmit service request pulse per channel |
| tx_clr | input | 2 | Transmit service done pulse per channel |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel (A in [1:0]) |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| stat_hi | input | 1 | Places the code in vector bits 6:4 when 1, bits 3:1 when 0 |
| irq | output | 1 | Registered interrupt request |
| pend | output | 4 | Pending bits {A rx, A tx, B rx, B tx} |
| vec | output | 8 | Modified interrupt vector |

## Verification
The directed cases are chosen to separate specific behaviours:
- A receive raise followed by a transmit raise on the same channel tells receive precedence in the vector apart from last-writer-wins.
- Clearing receive with transmit still pending tells re-raising apart from a plain clear to the no-interrupt code.
- Transmit raises with the enable off distinguish the internal request from the visible pending bit.
- Receive modes 00 and 11, and break status with and without its enable, separate the three request terms.
- Simultaneous events on both channels, and a set together with a clear, pin down the ordering rules.

Random event and configuration streams, under both placement settings, then exercise every interaction against a bench model.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int NUM_CH  = 2;
    localparam int CODE_W  = 3;
    localparam int VEC_W   = 8;
    localparam int MODE_W  = 2;
    localparam int PEND_W  = 2 * NUM_CH;

    localparam logic [CODE_W-1:0] CODE_NONE = 3'b011;

    typedef struct packed {
        logic rx_req;
        logic tx_req;
        logic tx_pend;
    } chan_st_t;

    typedef struct packed {
        logic             irq;
        logic [VEC_W-1:0] vec;
    } top_st_t;

    function automatic logic [CODE_W-1:0] src_code(input logic is_a, input logic is_rx);
        return {is_a, is_rx, 1'b0};
    endfunction
endpackage

// File: rtl/ivec_chan.sv
module ivec_chan
    import ivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_set,
    input  logic              rx_clr,
    input  logic              tx_set,
    input  logic              tx_clr,
    input  logic              tx_ie,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic              brk_ie,
    input  logic              brk_stat,
    output logic              rx_req_q,
    output logic              tx_req_q,
    output logic              tx_pend_q,
    output logic              rx_req_nxt,
    output logic              tx_req_nxt,
    output logic              req_nxt,
    output logic              any_ev
);
    chan_st_t st_d, st_q;
    logic     rx_irq_mode;

    always_comb begin
        st_d        = st_q;
        st_d.rx_req = rx_set | (st_q.rx_req & ~rx_clr);
        st_d.tx_req = tx_set | (st_q.tx_req & ~tx_clr);
        // transmit pending bit: raised on set or on re-raise after an rx clear
        st_d.tx_pend = (tx_ie & (tx_set | (rx_clr & st_d.tx_req)))
                     | (st_q.tx_pend & ~tx_clr);
        rx_irq_mode = (rx_mode == 2'b01) || (rx_mode == 2'b10);
        req_nxt     = (tx_ie & st_d.tx_req) | (rx_irq_mode & st_d.rx_req)
                    | (brk_ie & brk_stat);
        any_ev      = rx_set | rx_clr | tx_set | tx_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_req_q   = st_q.rx_req;
    assign tx_req_q   = st_q.tx_req;
    assign tx_pend_q  = st_q.tx_pend;
    assign rx_req_nxt = st_d.rx_req;
    assign tx_req_nxt = st_d.tx_req;

    // R5: a lone transmit clear drops the pending bit
    a_r5_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !tx_set) |=> !tx_pend_q);
    // R3: a transmit raise with the enable off leaves the pending bit low
    a_r3_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_pend_q && tx_set && !tx_ie) |=> !tx_pend_q);
    // R2: a receive set is seen as a request next cycle
    a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> rx_req_q);
endmodule

// File: rtl/ivec_fmt.sv
module ivec_fmt
    import ivec_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              stat_hi,
    output logic [VEC_W-1:0]  vec
);
    localparam int LO_POS = 1;
    localparam int HI_POS = 4;

    always_comb begin
        vec = '0;
        if (stat_hi) vec[HI_POS +: CODE_W] = code;
        else         vec[LO_POS +: CODE_W] = code;
    end

    initial begin
        a_r4_code_fits: assert (HI_POS + CODE_W <= VEC_W);
    end
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
    import ivec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        rx_set,
    input  logic [NUM_CH-1:0]        rx_clr,
    input  logic [NUM_CH-1:0]        tx_set,
    input  logic [NUM_CH-1:0]        tx_clr,
    input  logic [NUM_CH-1:0]        tx_ie,
    input  logic [NUM_CH*MODE_W-1:0] rx_mode,
    input  logic [NUM_CH-1:0]        brk_ie,
    input  logic [NUM_CH-1:0]        brk_stat,
    input  logic                     stat_hi,
    output logic                     irq,
    output logic [PEND_W-1:0]        pend,
    output logic [VEC_W-1:0]         vec
);
    localparam logic [VEC_W-1:0] VEC_RST = VEC_W'({CODE_NONE, 1'b0});

    logic [NUM_CH-1:0] rx_req_q, tx_req_q, tx_pend_q;
    logic [NUM_CH-1:0] rx_req_nxt, tx_req_nxt, req_nxt, any_ev;
    logic [CODE_W-1:0] sel_code;
    logic [VEC_W-1:0]  fmt_vec;
    top_st_t           st_d, st_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ivec_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_set     (rx_set[c]),
            .rx_clr     (rx_clr[c]),
            .tx_set     (tx_set[c]),
            .tx_clr     (tx_clr[c]),
            .tx_ie      (tx_ie[c]),
            .rx_mode    (rx_mode[c*MODE_W +: MODE_W]),
            .brk_ie     (brk_ie[c]),
            .brk_stat   (brk_stat[c]),
            .rx_req_q   (rx_req_q[c]),
            .tx_req_q   (tx_req_q[c]),
            .tx_pend_q  (tx_pend_q[c]),
            .rx_req_nxt (rx_req_nxt[c]),
            .tx_req_nxt (tx_req_nxt[c]),
            .req_nxt    (req_nxt[c]),
            .any_ev     (any_ev[c])
        );
        // pending layout: channel 0 (A) in the upper pair, rx above tx
        assign pend[PEND_W-1-2*c] = rx_req_q[c];
        assign pend[PEND_W-2-2*c] = tx_pend_q[c];
    end

    // lowest channel index with an event owns the vector update
    always_comb begin
        sel_code = CODE_NONE;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (any_ev[c]) begin
                if (rx_req_nxt[c])      sel_code = src_code(c == 0, 1'b1);
                else if (tx_req_nxt[c]) sel_code = src_code(c == 0, 1'b0);
                else                    sel_code = CODE_NONE;
            end
        end
    end

    ivec_fmt u_fmt (
        .code    (sel_code),
        .stat_hi (stat_hi),
        .vec     (fmt_vec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |req_nxt;
        if (|any_ev) st_d.vec = fmt_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
            st_q.vec <= VEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
    assign vec = st_q.vec;

    // R7: an enabled receive raise on A drives the request line
    a_r7_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set[0] && rx_mode[1:0] == 2'b01) |=> irq);
    // R4: low placement keeps the upper nibble and bit 0 clear
    a_r4_low_form: assert property (@(posedge clk) disable iff (!rst_n)
        ((|any_ev) && !stat_hi) |=> (vec[7:4] == 4'h0 && vec[0] == 1'b0));
    // R6: clearing A receive with A transmit still requested re-raises transmit
    a_r6_reraise: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr[0] && !rx_set[0] && !tx_clr[0] && tx_req_q[0] && tx_ie[0])
        |=> (pend[2] && (vec[3:1] == 3'b100 || vec[6:4] == 3'b100)));
    // R9: a channel A event wins the vector over B
    a_r9_a_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set[0] && rx_set[1] && !stat_hi) |=> (vec[3:1] == 3'b110));
endmodule

// File: tb/test_ivec_ctrl.sv
module test_ivec_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
    logic [1:0] tx_ie = '0, brk_ie = '0, brk_stat = '0;
    logic [3:0] rx_mode = '0;
    logic       stat_hi = 1'b0;
    logic       irq;
    logic [3:0] pend;
    logic [7:0] vec;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model state
    logic [1:0] m_rx = '0, m_tx = '0, m_txp = '0;
    logic [7:0] m_vec = 8'h06;
    logic       m_irq = 1'b0;

    always #2 clk = ~clk;

    ivec_ctrl i_ivec_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_set(rx_set), .rx_clr(rx_clr),
        .tx_set(tx_set), .tx_clr(tx_clr), .tx_ie(tx_ie), .rx_mode(rx_mode),
        .brk_ie(brk_ie), .brk_stat(brk_stat), .stat_hi(stat_hi),
        .irq(irq), .pend(pend), .vec(vec)
    );

    function automatic logic [7:0] fmt(input logic [2:0] code, input logic hi);
        return hi ? {1'b0, code, 4'h0} : {4'h0, code, 1'b0};
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // apply requirement rules to the model for the inputs now driven
    task automatic model_step();
        logic [1:0] rx_n, tx_n, txp_n;
        logic       req;
        logic       done;
        req  = 1'b0;
        done = 1'b0;
        for (int c = 0; c < 2; c++) begin
            rx_n[c]  = rx_set[c] | (m_rx[c] & ~rx_clr[c]);
            tx_n[c]  = tx_set[c] | (m_tx[c] & ~tx_clr[c]);
            txp_n[c] = (tx_ie[c] & (tx_set[c] | (rx_clr[c] & tx_n[c]))) | (m_txp[c] & ~tx_clr[c]);
            req = req | (tx_ie[c] & tx_n[c])
                      | (((rx_mode[2*c +: 2] == 2'b01) || (rx_mode[2*c +: 2] == 2'b10)) & rx_n[c])
                      | (brk_ie[c] & brk_stat[c]);
        end
        for (int c = 0; c < 2; c++) begin
            if (!done && (rx_set[c] | rx_clr[c] | tx_set[c] | tx_clr[c])) begin
                done = 1'b1;
                if (rx_n[c])      m_vec = fmt({c == 0, 2'b10}, stat_hi);
                else if (tx_n[c]) m_vec = fmt({c == 0, 2'b00}, stat_hi);
                else              m_vec = fmt(3'b011, stat_hi);
            end
        end
        m_rx = rx_n; m_tx = tx_n; m_txp = txp_n; m_irq = req;
    endtask

    task automatic step(input string req);
        model_step();
        @(posedge clk);
        #1;
        check(req, "irq", {7'b0, irq}, {7'b0, m_irq});
        check(req, "pend", {4'b0, pend}, {4'b0, m_txp[1] ? 4'b0 : 4'b0} | {4'b0, m_rx[0], m_txp[0], m_rx[1], m_txp[1]});
        check(req, "vec", vec, m_vec);
        @(negedge clk);
        rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0;
    endtask

    initial begin : watchdog
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1", "irq", {7'b0, irq}, 8'h00);
        check("R1", "pend", {4'b0, pend}, 8'h00);
        check("R1", "vec", vec, 8'h06);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R7: A receive raise, mode 01
        rx_mode = 4'b0001; tx_ie = 2'b01;
        rx_set = 2'b01; step("R2");
        check("R2", "vec literal", vec, 8'h0C);
        // R3: A transmit raise while receive pending keeps receive code
        tx_set = 2'b01; step("R3");
        check("R3", "vec literal", vec, 8'h0C);
        // R6: clear receive, transmit re-raised
        rx_clr = 2'b01; step("R6");
        check("R6", "vec literal", vec, 8'h08);
        check("R6", "pend literal", {4'b0, pend}, 8'h04);
        // R5: clear transmit, no-interrupt code
        tx_clr = 2'b01; step("R5");
        check("R5", "vec literal", vec, 8'h06);
        check("R5", "irq literal", {7'b0, irq}, 8'h00);

        // R4: high placement, B receive then clear
        stat_hi = 1'b1; rx_mode = 4'b0100;
        rx_set = 2'b10; step("R4");
        check("R4", "vec literal", vec, 8'h20);
        rx_clr = 2'b10; step("R4");
        check("R4", "vec none high", vec, 8'h30);

        // R3: B transmit with enable off: no pending bit, no irq
        tx_ie = 2'b00; tx_set = 2'b10; step("R3");
        check("R3", "pend masked", {4'b0, pend}, 8'h00);
        check("R3", "irq masked", {7'b0, irq}, 8'h00);
        check("R3", "vec B tx", vec, 8'h00);
        tx_clr = 2'b10; step("R5");

        // R7: mode 11 does not request
        stat_hi = 1'b0; rx_mode = 4'b0011;
        rx_set = 2'b01; step("R7");
        check("R7", "mode 11 irq", {7'b0, irq}, 8'h00);
        rx_clr = 2'b01; step("R7");

        // R8: break request appears one edge later
        brk_ie = 2'b10; brk_stat = 2'b10;
        #1;
        check("R8", "irq before edge", {7'b0, irq}, 8'h00);
        step("R8");
        check("R8", "irq after edge", {7'b0, irq}, 8'h01);
        brk_stat = 2'b00; step("R8");

        // R9: both channels at once, A wins; set beats clear
        rx_mode = 4'b0101;
        rx_set = 2'b11; step("R9");
        check("R9", "A wins", vec, 8'h0C);
        rx_set = 2'b01; rx_clr = 2'b01; step("R9");
        check("R9", "set beats clear", {4'b0, pend}, 8'h0A);
        rx_clr = 2'b11; step("R9");

        // random phase
        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            rx_set   = r[1:0] & {r[16], r[17]};
            rx_clr   = r[3:2] & {r[18], r[19]};
            tx_set   = r[5:4] & {r[20], r[21]};
            tx_clr   = r[7:6] & {r[22], r[23]};
            tx_ie    = r[9:8];
            rx_mode  = r[13:10];
            brk_ie   = r[15:14];
            brk_stat = r[25:24];
            stat_hi  = r[26];
            step("R2 R3 R5 R6 R7 R9");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule